// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block sits between a host-side request port and a 32-bit, memory-style downstream port that reaches a PCI bus bridge. A host asks for one configuration access: bus, device, function, register offset, size in bytes, and direction. The block checks that the request is legal. It then prepares the upper address bits in a window register and issues word accesses downstream. Read data comes back as the requested byte lanes. Sub-word writes are merged into the existing word.

Requests on bus 0 are Type 0 accesses. The target is chosen by a one-hot select line, and that one-hot value is split between the window register and the issued address. Requests on any other bus are forwarded as Type 1 addresses. A strap input selects a single-slot card mode, in which only device 0 may be addressed.

The downstream port can signal a fault on any access. Both a fault and an illegal request are reported to the host as "device not found". Requests are served one at a time.

Top module: `cfg_xlat`

## Requirements
- R1: `req_size` holds a byte count. Only 1, 2 and 4 are legal. Any other value gives a response with `resp_err`=1 and `resp_rdata`=0 in the cycle after acceptance, with no downstream access and `win_reg` unchanged.
- R2: A request with `req_bus`=0 and `req_dev` of 16 or more is rejected in the same way as R1.
- R3: With `cardbus_mode`=1, any request with `req_dev` other than 0 is rejected in the same way as R1, whatever the bus number.
- R4: A legal request on bus 0 forms the one-hot value H = 1 << (dev+16). Before its first access, `win_reg` becomes (H & 0xFC000000) | 0b10. The issued address is (H & 0x03FFFFFF) | func<<8 | (offset & 0xFC), so address bits 1:0 are 00.
- R5: A legal request on a non-zero bus first loads `win_reg` with 0x00000003. The issued address is bus<<16 | dev<<11 | func<<8 | (offset & 0xFC) | 0b01.
- R6: A read issues one downstream read of word W. The response data is (W >> 8×(offset mod 4)), masked to its low 8, 16 or 32 bits by the size, with the upper bits zero, and `resp_err`=0.
- R7: Every legal write first reads word W and then writes one word to the same address. For size 4 the written word is the request data. For size 1 or 2, the 0xFF or 0xFFFF lane at bit 8×(offset mod 4) is cleared and filled with the low bits of the data; lane bits beyond bit 31 are dropped. A write response carries `resp_rdata`=0.
- R8: A fault (`mem_err`=1 with `mem_ready`) on the first read ends the request with `resp_err`=1 and `resp_rdata`=0, and no write is issued. A fault on the write-back also gives `resp_err`=1.
- R9: `req_ready` is low from the cycle after acceptance until the cycle after the one-cycle `resp_valid` pulse, so a request held during that time is not accepted.
- R10: After reset, `req_ready`=1, `resp_valid`=0, `mem_valid`=0 and `win_reg`=0.
- R11: While `mem_valid`=1 and `mem_ready`=0, `mem_addr`, `mem_write` and `mem_wdata` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cardbus_mode | input | 1 | Single-slot card mode strap |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_off | input | 8 | Register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_err | output | 1 | Device not found |
| resp_rdata | output | 32 | Read data, right-aligned |
| win_reg | output | 32 | Window register: upper select bits and type tag |
| mem_valid | output | 1 | Downstream access request |
| mem_write | output | 1 | Downstream access is a write |
| mem_addr | output | 32 | Downstream word address |
| mem_wdata | output | 32 | Downstream write word |
| mem_ready | input | 1 | Downstream access complete |
| mem_rdata | input | 32 | Downstream read word |
| mem_err | input | 1 | Downstream fault with completion |

## Verification
Two things can happen in the same cycle. The response pulse of one request can coincide with a new request that the host is already holding. The bench provokes this by raising the next request right after the previous one is accepted, and by using random downstream latencies so that the response lands in varied cycles. It then compares `req_ready` with its own busy model on every clock, and checks that the held request is taken only after the pulse. A fault can also arrive in the same completion cycle that would otherwise start a write-back. This is provoked by writes to addresses that the bench's memory model marks as faulting, and it is judged by the access count and the error flag.

// File: rtl/cfg_xlat_pkg.sv
package cfg_xlat_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROBE = 2'd1,
    ST_WBACK = 2'd2,
    ST_RESP  = 2'd3
  } xl_state_e;

  localparam logic [1:0] TAG_T0 = 2'b10;
  localparam logic [1:0] TAG_T1 = 2'b11;

  // Lane mask for a size, placed at byte position lo.
  function automatic logic [31:0] lane_mask(input logic [2:0] size, input logic [1:0] lo);
    logic [31:0] m;
    case (size)
      3'd1:    m = 32'h0000_00FF;
      3'd2:    m = 32'h0000_FFFF;
      default: m = 32'hFFFF_FFFF;
    endcase
    return m << {lo, 3'b000};
  endfunction

  function automatic logic [31:0] lane_pick(input logic [31:0] word, input logic [2:0] size,
                                            input logic [1:0] lo);
    return (word >> {lo, 3'b000}) & lane_mask(size, 2'b00);
  endfunction

  function automatic logic [31:0] lane_merge(input logic [31:0] old, input logic [31:0] data,
                                             input logic [2:0] size, input logic [1:0] lo);
    logic [31:0] m;
    if (size == 3'd4) return data;
    m = lane_mask(size, lo);
    return (old & ~m) | ((data & lane_mask(size, 2'b00)) << {lo, 3'b000});
  endfunction

endpackage

// File: rtl/cfg_xlat_decode.sv
module cfg_xlat_decode
  import cfg_xlat_pkg::*;
#(
  parameter int BUS_W      = 8,
  parameter int DEV_W      = 5,
  parameter int FN_W       = 3,
  parameter int OFF_W      = 8,
  parameter int SLOT_MAX   = 16,
  parameter int IDSEL_BASE = 16,
  parameter int WIN_LSB    = 26
) (
  input  logic [BUS_W-1:0]   bus,
  input  logic [DEV_W-1:0]   dev,
  input  logic [FN_W-1:0]    func,
  input  logic [OFF_W-3:0]   off_word,
  input  logic [2:0]         size,
  input  logic               cardbus,
  output logic               legal,
  output logic [31:0]        tgt_addr,
  output logic [31:0]        win_val
);
  localparam int FN_LSB  = 8;
  localparam int DEV_LSB = FN_LSB + FN_W;
  localparam int BUS_LSB = DEV_LSB + DEV_W;
  localparam logic [31:0]  WIN_MASK = ~((32'd1 << WIN_LSB) - 32'd1);
  localparam logic [DEV_W:0] SLOT_LIM = (DEV_W+1)'(SLOT_MAX);
  localparam logic [DEV_W:0] SEL_BASE = (DEV_W+1)'(IDSEL_BASE);

  logic        size_ok, dev_ok, card_ok, type0;
  logic [31:0] hot, low_fields;

  assign type0   = (bus == '0);
  assign size_ok = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
  assign dev_ok  = !type0 || ({1'b0, dev} < SLOT_LIM);
  assign card_ok = !cardbus || (dev == '0);
  assign legal   = size_ok && dev_ok && card_ok;

  assign hot        = 32'd1 << ({1'b0, dev} + SEL_BASE);
  assign low_fields = (32'(func) << FN_LSB) | 32'({off_word, 2'b00});

  always_comb begin
    if (type0) begin
      win_val  = (hot & WIN_MASK) | 32'(TAG_T0);
      tgt_addr = (hot & ~WIN_MASK) | low_fields;
    end else begin
      win_val  = 32'(TAG_T1);
      tgt_addr = (32'(bus) << BUS_LSB) | (32'(dev) << DEV_LSB) | low_fields | 32'd1;
    end
  end
endmodule

// File: rtl/cfg_xlat_lane.sv
module cfg_xlat_lane
  import cfg_xlat_pkg::*;
(
  input  logic [31:0] word,
  input  logic [31:0] wdata,
  input  logic [2:0]  size,
  input  logic [1:0]  lo,
  output logic [31:0] rd_val,
  output logic [31:0] wr_word
);
  assign rd_val  = lane_pick(word, size, lo);
  assign wr_word = lane_merge(word, wdata, size, lo);
endmodule

// File: rtl/cfg_xlat_ctrl.sv
module cfg_xlat_ctrl
  import cfg_xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [2:0]  req_size,
  input  logic [1:0]  req_lo,
  input  logic [31:0] req_wdata,
  input  logic        dec_legal,
  input  logic [31:0] dec_addr,
  input  logic [31:0] dec_win,
  input  logic [31:0] lane_rd,
  input  logic [31:0] lane_wr,
  output logic [2:0]  cap_size,
  output logic [1:0]  cap_lo,
  output logic [31:0] cap_wdata,
  output logic        cap_write,
  output logic        accept_ev,
  output logic        resp_valid,
  output logic        resp_err,
  output logic [31:0] resp_rdata,
  output logic [31:0] win_reg,
  output logic        mem_valid,
  output logic        mem_write,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic        mem_err
);
  xl_state_e   st;
  logic [31:0] addr_q, win_q, wword_q, rdata_q, wdata_q;
  logic [2:0]  size_q;
  logic [1:0]  lo_q;
  logic        err_q, wr_q;
  logic        probe_done, wb_done;

  assign req_ready  = (st == ST_IDLE);
  assign accept_ev  = req_valid && req_ready;
  assign probe_done = (st == ST_PROBE) && mem_ready;
  assign wb_done    = (st == ST_WBACK) && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      addr_q  <= '0;
      win_q   <= '0;
      wword_q <= '0;
      rdata_q <= '0;
      wdata_q <= '0;
      size_q  <= '0;
      lo_q    <= '0;
      err_q   <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (accept_ev) begin
            size_q  <= req_size;
            lo_q    <= req_lo;
            wdata_q <= req_wdata;
            wr_q    <= req_write;
            rdata_q <= '0;
            err_q   <= !dec_legal;
            if (dec_legal) begin
              win_q  <= dec_win;
              addr_q <= dec_addr;
              st     <= ST_PROBE;
            end else begin
              st     <= ST_RESP;
            end
          end
        end
        ST_PROBE: begin
          if (probe_done) begin
            if (mem_err) begin
              err_q <= 1'b1;
              st    <= ST_RESP;
            end else if (wr_q) begin
              wword_q <= lane_wr;
              st      <= ST_WBACK;
            end else begin
              rdata_q <= lane_rd;
              st      <= ST_RESP;
            end
          end
        end
        ST_WBACK: begin
          if (wb_done) begin
            err_q <= mem_err;
            st    <= ST_RESP;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cap_size   = size_q;
  assign cap_lo     = lo_q;
  assign cap_wdata  = wdata_q;
  assign cap_write  = wr_q;
  assign resp_valid = (st == ST_RESP);
  assign resp_err   = err_q;
  assign resp_rdata = rdata_q;
  assign win_reg    = win_q;
  assign mem_valid  = (st == ST_PROBE) || (st == ST_WBACK);
  assign mem_write  = (st == ST_WBACK);
  assign mem_addr   = addr_q;
  assign mem_wdata  = wword_q;
endmodule

// File: rtl/cfg_xlat.sv
module cfg_xlat
  import cfg_xlat_pkg::*;
#(
  parameter int BUS_W      = 8,
  parameter int DEV_W      = 5,
  parameter int FN_W       = 3,
  parameter int OFF_W      = 8,
  parameter int SLOT_MAX   = 16,
  parameter int IDSEL_BASE = 16,
  parameter int WIN_LSB    = 26
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cardbus_mode,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [BUS_W-1:0]   req_bus,
  input  logic [DEV_W-1:0]   req_dev,
  input  logic [FN_W-1:0]    req_func,
  input  logic [OFF_W-1:0]   req_off,
  input  logic [2:0]         req_size,
  input  logic [31:0]        req_wdata,
  output logic               resp_valid,
  output logic               resp_err,
  output logic [31:0]        resp_rdata,
  output logic [31:0]        win_reg,
  output logic               mem_valid,
  output logic               mem_write,
  output logic [31:0]        mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic               mem_ready,
  input  logic [31:0]        mem_rdata,
  input  logic               mem_err
);
  logic        legal_ev, accept_ev, cap_write;
  logic [31:0] dec_addr, dec_win, lane_rd, lane_wr, cap_wdata;
  logic [2:0]  cap_size;
  logic [1:0]  cap_lo;

  cfg_xlat_decode #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFF_W(OFF_W),
    .SLOT_MAX(SLOT_MAX), .IDSEL_BASE(IDSEL_BASE), .WIN_LSB(WIN_LSB)
  ) u_dec (
    .bus(req_bus), .dev(req_dev), .func(req_func), .off_word(req_off[OFF_W-1:2]),
    .size(req_size), .cardbus(cardbus_mode),
    .legal(legal_ev), .tgt_addr(dec_addr), .win_val(dec_win)
  );

  cfg_xlat_lane u_lane (
    .word(mem_rdata), .wdata(cap_wdata), .size(cap_size), .lo(cap_lo),
    .rd_val(lane_rd), .wr_word(lane_wr)
  );

  cfg_xlat_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_lo(req_off[1:0]), .req_wdata(req_wdata),
    .dec_legal(legal_ev), .dec_addr(dec_addr), .dec_win(dec_win),
    .lane_rd(lane_rd), .lane_wr(lane_wr),
    .cap_size(cap_size), .cap_lo(cap_lo), .cap_wdata(cap_wdata), .cap_write(cap_write),
    .accept_ev(accept_ev),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
    .win_reg(win_reg),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_err(mem_err)
  );
endmodule

// File: rtl/cfg_xlat_chk.sv
module cfg_xlat_chk #(
  parameter int WIN_LSB    = 26,
  parameter int IDSEL_BASE = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        resp_valid,
  input logic        resp_err,
  input logic [31:0] win_reg,
  input logic        mem_valid,
  input logic        mem_write,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ready,
  input logic        mem_err,
  input logic        accept_ev,
  input logic        legal_ev,
  input logic        cap_write
);
  p_illegal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev && !legal_ev |=> resp_valid && resp_err && !mem_valid && $stable(win_reg));

  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && (win_reg[1:0] == 2'b10) |->
      ($countones({win_reg[31:WIN_LSB], mem_addr[WIN_LSB-1:IDSEL_BASE]}) == 1)
      && (mem_addr[1:0] == 2'b00));

  p_type1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && (win_reg[1:0] == 2'b11) |->
      (mem_addr[1:0] == 2'b01) && (win_reg[31:2] == '0));

  p_wback_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_write && mem_ready && !mem_err && cap_write |=> mem_valid && mem_write);

  p_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && mem_err |=> resp_valid && resp_err && !mem_valid);

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready);

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=>
      mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata));
endmodule

bind cfg_xlat cfg_xlat_chk #(.WIN_LSB(WIN_LSB), .IDSEL_BASE(IDSEL_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .resp_valid(resp_valid),
  .resp_err(resp_err), .win_reg(win_reg), .mem_valid(mem_valid), .mem_write(mem_write),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_err(mem_err),
  .accept_ev(accept_ev), .legal_ev(legal_ev), .cap_write(cap_write)
);

// File: tb/tb_cfg_xlat.sv
module tb_cfg_xlat;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, cardbus_mode = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_bus = '0, req_off = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_func = '0, req_size = 3'd4;
  logic [31:0] req_wdata = '0;
  logic        req_ready, resp_valid, resp_err;
  logic [31:0] resp_rdata, win_reg, mem_addr, mem_wdata;
  logic        mem_valid, mem_write;
  logic        mem_ready = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;

  cfg_xlat dut (
    .clk(clk), .rst_n(rst_n), .cardbus_mode(cardbus_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func), .req_off(req_off),
    .req_size(req_size), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
    .win_reg(win_reg), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .mem_err(mem_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Downstream memory model
  logic [31:0] mem [logic [31:0]];
  bit          errmap [logic [31:0]];

  function automatic logic [31:0] peek(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 32'h5A3C_96E1;
  endfunction

  // Reference model state
  bit          busy = 0, pend = 0;
  logic [31:0] model_win = '0, stage_win = '0;
  logic [31:0] exp_addr, exp_rdata, exp_wword;
  bit          exp_err, x_write, x_legal;
  int          exp_acc, acc_cnt, lat, wcnt;
  logic [2:0]  x_size;
  logic [1:0]  x_lo;
  logic [31:0] x_wdata;

  // Address model for R4 / R5, done with integer arithmetic
  task automatic form_target(input int bus, input int dev, input int fn, input int off,
                             output logic [31:0] a, output logic [31:0] w);
    longint hot;
    if (bus == 0) begin
      hot = longint'(1) << (dev + 16);
      w = 32'(((hot >> 26) << 26) + 2);
      a = 32'((hot % (longint'(1) << 26)) + fn * 256 + (off / 4) * 4);
    end else begin
      w = 32'd3;
      a = 32'(bus * 65536 + dev * 2048 + fn * 256 + (off / 4) * 4 + 1);
    end
  endtask

  function automatic logic [31:0] lanes(input int size);
    return (size == 1) ? 32'hFF : (size == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic predict();
    int bus, dev, fn, off, size, sh;
    logic [31:0] a, w, word, m64;
    bus = int'(req_bus); dev = int'(req_dev); fn = int'(req_func);
    off = int'(req_off); size = int'(req_size);
    sh = 8 * (off % 4);
    x_write = req_write; x_size = req_size; x_lo = req_off[1:0]; x_wdata = req_wdata;
    x_legal = (size == 1 || size == 2 || size == 4) && !(cardbus_mode && dev != 0)
              && !(bus == 0 && dev >= 16);
    exp_rdata = 0; exp_wword = 0; exp_acc = 0; exp_err = !x_legal;
    stage_win = model_win;
    if (x_legal) begin
      form_target(bus, dev, fn, off, a, w);
      stage_win = w; exp_addr = a;
      word = peek(a);
      exp_acc = 1;
      if (errmap.exists(a)) exp_err = 1;
      else if (!x_write) exp_rdata = (word >> sh) & lanes(size);
      else begin
        exp_acc = 2;
        if (size == 4) exp_wword = req_wdata;
        else begin
          m64 = 32'(64'(lanes(size)) << sh);
          exp_wword = (word & ~m64) | 32'(64'(req_wdata & lanes(size)) << sh);
        end
      end
    end
  endtask

  // Per-clock comparison and downstream responder
  always @(negedge clk) begin
    if (!rst_n) begin
      busy = 0; pend = 0; mem_ready = 0; mem_err = 0; wcnt = 0;
    end else begin
      if (pend) begin busy = 1; pend = 0; model_win = stage_win; end
      chk(req_ready == !busy, "R9 ready vs busy model", 32'(req_ready), 32'(!busy));
      chk(win_reg == model_win, "R1/R4/R5 window register", win_reg, model_win);
      if (mem_valid && !busy) chk(0, "R1 access while idle", 1, 0);
      if (mem_ready) begin
        mem_ready = 0; mem_err = 0;
      end else if (mem_valid) begin
        if (wcnt < lat) wcnt++;
        else begin
          wcnt = 0; acc_cnt++;
          chk(mem_addr == exp_addr, win_reg[0] ? "R5 type1 address" : "R4 type0 address",
              mem_addr, exp_addr);
          if (mem_write) begin
            chk(acc_cnt == 2, "R7 write follows probe read", 32'(acc_cnt), 2);
            chk(mem_wdata == exp_wword, "R7 merged word", mem_wdata, exp_wword);
            mem[mem_addr] = mem_wdata;
          end else begin
            chk(acc_cnt == 1, "R6 single probe read", 32'(acc_cnt), 1);
            mem_rdata = peek(mem_addr);
          end
          mem_err = errmap.exists(mem_addr);
          mem_ready = 1;
          lat = $urandom_range(0, 2);
        end
      end
      if (resp_valid) begin
        chk(busy, "R9 response only while busy", 32'(resp_valid), 32'(busy));
        chk(resp_err == exp_err, x_legal ? "R8 error flag" : "R1/R2/R3 reject",
            32'(resp_err), 32'(exp_err));
        chk(resp_rdata == exp_rdata, x_write ? "R7 write response data" : "R6 read lanes",
            resp_rdata, exp_rdata);
        chk(acc_cnt == exp_acc, "R1/R8 downstream access count", 32'(acc_cnt), 32'(exp_acc));
        busy = 0;
      end
      if (req_valid && req_ready) begin
        predict(); pend = 1; acc_cnt = 0;
      end
    end
  end

  task automatic send(input bit w, input int bus, input int dev, input int fn,
                      input int off, input int size, input logic [31:0] wd);
    @(posedge clk); #1;
    req_write = w; req_bus = 8'(bus); req_dev = 5'(dev); req_func = 3'(fn);
    req_off = 8'(off); req_size = 3'(size); req_wdata = wd; req_valid = 1;
    forever begin @(negedge clk); if (req_ready) break; end
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic settle();
    forever begin @(negedge clk); #1; if (!busy && !pend) break; end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] fa, fw;
    lat = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    chk(req_ready && !resp_valid && !mem_valid && win_reg == 0, "R10 reset state",
        {req_ready, resp_valid, mem_valid, 29'(win_reg != 0)}, 32'h8000_0000);

    // Type 0 reads with window and address parts of the select (R4, R6)
    send(0, 0, 0, 0, 8'h00, 4, 0);  settle();
    send(0, 0, 12, 3, 8'h16, 2, 0); settle();
    send(0, 0, 9, 5, 8'h43, 1, 0);  settle();
    send(0, 0, 15, 7, 8'hFD, 4, 0); settle();
    send(0, 0, 4, 1, 8'h27, 2, 0);  settle();
    // Type 1 (R5)
    send(0, 3, 20, 2, 8'h44, 4, 0); settle();
    send(0, 255, 31, 7, 8'hFE, 2, 0); settle();
    // Illegal sizes and devices (R1, R2)
    send(0, 0, 1, 0, 0, 3, 0); settle();
    send(1, 0, 1, 0, 0, 0, 32'h1); settle();
    send(0, 1, 1, 0, 0, 7, 0); settle();
    send(0, 0, 16, 0, 0, 4, 0); settle();
    send(1, 0, 31, 0, 0, 1, 32'h7); settle();
    // Single-slot mode (R3)
    cardbus_mode = 1;
    send(0, 0, 1, 0, 0, 4, 0); settle();
    send(0, 2, 5, 0, 0, 4, 0); settle();
    send(0, 0, 0, 2, 8'h10, 4, 0); settle();
    send(0, 6, 0, 1, 8'h0C, 1, 0); settle();
    cardbus_mode = 0;
    // Writes and read-back (R7)
    send(1, 0, 2, 0, 8'h11, 1, 32'hABCD_EF5A); settle();
    send(0, 0, 2, 0, 8'h10, 4, 0); settle();
    send(1, 0, 2, 0, 8'h13, 2, 32'h0000_BEEF); settle();
    send(0, 0, 2, 0, 8'h10, 4, 0); settle();
    send(1, 4, 9, 1, 8'h22, 4, 32'h1234_5678); settle();
    send(0, 4, 9, 1, 8'h20, 4, 0); settle();
    // Faults (R8)
    form_target(1, 3, 0, 8'h20, fa, fw);
    errmap[fa] = 1;
    send(0, 1, 3, 0, 8'h20, 4, 0); settle();
    send(1, 1, 3, 0, 8'h21, 1, 32'hFF); settle();
    form_target(0, 11, 0, 8'h08, fa, fw);
    errmap[fa] = 1;
    send(1, 0, 11, 0, 8'h08, 4, 32'hCAFE); settle();
    // Requests held during the response (R9)
    for (int i = 0; i < 6; i++) send(i % 2, 0, i, 0, 4 * i + 1, (i % 3 == 2) ? 4 : 1, 32'h100 + i);
    settle();
    // Random patterns
    for (int i = 0; i < 300; i++) begin
      cardbus_mode = ($urandom_range(0, 9) == 0);
      send($urandom_range(0, 1), ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(0, 255),
           $urandom_range(0, 31) % (($urandom_range(0, 1) == 0) ? 17 : 32),
           $urandom_range(0, 7), $urandom_range(0, 255),
           ($urandom_range(0, 7) == 0) ? $urandom_range(0, 7) : (1 << $urandom_range(0, 2)),
           $urandom());
      if ($urandom_range(0, 1) == 0) settle();
    end
    settle();
    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule